// File: doc/BRIEF.md
# Operator Envelope Generator

This block shapes the loudness of one synthesis operator over time. It keeps a 9-bit attenuation level, where 0x1FF is silence, and moves it through five stages: off, attack, decay, sustain and release. Each stage's speed comes from a 4-bit rate field that is scaled by a key-scale value. The increment applied in a given cycle depends on that rate and on a free-running sample counter that the block receives from outside. The attack stage falls exponentially toward zero. Decay and release rise linearly.

A note starts when either of two independent key sources is raised, and it ends when both have been dropped. The output is the operator's total attenuation. It is the sum of four terms: the envelope level, a total-level offset, a pitch-dependent key-scale attenuation and a tremolo value. The next stage in the pipeline turns this sum into amplitude. Each clock cycle is one sample step.

Top module: `env_adsr`

## Requirements
- R1: While `rst_n` is low the block is in the off stage with level 0x1FF. The `stage` output uses the encoding off=0, attack=1, decay=2, sustain=3, release=4.
- R2: Effective rate for a 4-bit field r:
  - It is 0 when r is 0.
  - Otherwise it is 4·r plus `ksv` when `ksr_en` is 1, or 4·r plus `ksv`>>2 when `ksr_en` is 0.
  - The result saturates at 60.
- R3: Rate field per stage: attack uses `ar`, decay uses `dr`, sustain and release use `rr`, and off uses rate 0.
- R4: Per-cycle increment. Let g be rate[5:2] and l be rate[1:0].
  - g=0 gives 0.
  - For g in 1..12, the increment is 0 unless `ctr` mod 2^(13−g) is 0. When it is 0, the increment is bit p of the mask {0xAA,0xBA,0xEE,0xFE}[l], where p = (`ctr`>>(13−g)) mod 8.
  - For g in 13..15, the increment is (1 + bit (`ctr` mod 8) of {0x00,0x88,0xAA,0xEE}[l]) << (g−13).
- R5: Attack stage:
  - If the level is 0, the stage becomes decay.
  - Otherwise the level becomes level − ceil((level+1)·inc/8), clamped at 0.
- R6: Decay stage. The threshold is `sl`·16, and an `sl` of 15 counts as 31, giving 496.
  - Once the level is at or above the threshold, the stage becomes sustain.
  - Until then the level rises by inc each cycle.
- R7: Sustain stage:
  - With `sus_hold`=1 the level is held.
  - With `sus_hold`=0 it behaves exactly as release, including the move to off. The stage output stays 3 until that move.
- R8: Release stage:
  - At level 0x1FF the stage becomes off.
  - Otherwise the level rises by inc, saturating at 0x1FF.
  - The off stage keeps the level at 0x1FF.
- R9: A rising edge of `key_a`|`key_b` (the combined key) pulses `ph_rst` in the same cycle. At the next edge the stage becomes attack. If the attack effective rate has rate[5:2]=15, the stage becomes decay with the level at 0 instead. No level step is taken in a key-event cycle.
- R10: Release is entered only at the edge where the combined key falls, that is, when both sources are low. A source rising or falling while the other source is held has no effect.
- R11: Key-scale attenuation. Let T be the table {0,32,40,45,48,51,53,55,56,58,59,60,61,62,63,64}, indexed by `fnum_hi`.
  - The raw value is T[`fnum_hi`]·4 − (8−`blk`)·32, clamped at 0.
  - `ksl_sel` then scales it: 0 gives 0, 1 gives raw>>1, 2 gives raw>>2, 3 gives raw.
- R12: `att` = level + `tl`·4 + key-scale attenuation + `trem`. The sum is not saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_a | input | 1 | First key source |
| key_b | input | 1 | Second key source |
| ar | input | 4 | Attack rate field |
| dr | input | 4 | Decay rate field |
| sl | input | 4 | Sustain level field |
| rr | input | 4 | Release rate field |
| sus_hold | input | 1 | Hold level in sustain when 1 |
| ksr_en | input | 1 | Full key-scale rate when 1 |
| ksv | input | 4 | Key scale value |
| ksl_sel | input | 2 | Key-scale attenuation select |
| fnum_hi | input | 4 | Top four bits of frequency number |
| blk | input | 3 | Octave block |
| tl | input | 6 | Total level |
| trem | input | TREM_W | Tremolo attenuation |
| ctr | input | CTR_W | Global sample counter |
| att | output | ATT_W | Total attenuation |
| stage | output | 3 | Current stage |
| ph_rst | output | 1 | Phase reset pulse on note start |

## Verification
Two things can happen in the same cycle: a key event and a stage's own exit condition. Examples are a key-off in the cycle where decay reaches its threshold, and a key-on in the cycle where release reaches 0x1FF. The key event must win, and no level step may be taken in that cycle. Random toggling of both key sources against fast rates creates these collisions. A bench model then judges each cycle by comparing both the stage and the attenuation with the values the requirements predict.

// File: rtl/env_adsr.sv
module env_adsr #(
  parameter int CTR_W  = 16,
  parameter int TREM_W = 5,
  localparam int ATT_W = (TREM_W > 9) ? TREM_W + 2 : 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_a,
  input  logic              key_b,
  input  logic [3:0]        ar,
  input  logic [3:0]        dr,
  input  logic [3:0]        sl,
  input  logic [3:0]        rr,
  input  logic              sus_hold,
  input  logic              ksr_en,
  input  logic [3:0]        ksv,
  input  logic [1:0]        ksl_sel,
  input  logic [3:0]        fnum_hi,
  input  logic [2:0]        blk,
  input  logic [5:0]        tl,
  input  logic [TREM_W-1:0] trem,
  input  logic [CTR_W-1:0]  ctr,
  output logic [ATT_W-1:0]  att,
  output logic [2:0]        stage,
  output logic              ph_rst
);

  typedef enum logic [2:0] {
    ST_OFF = 3'd0, ST_ATK = 3'd1, ST_DEC = 3'd2, ST_SUS = 3'd3, ST_REL = 3'd4
  } st_t;

  localparam logic [8:0]       SILENT = 9'h1FF;
  localparam logic [CTR_W-1:0] ONE    = 1;

  st_t        st, st_n;
  logic [8:0] lvl, lvl_n;
  logic       key_held, key_now, kon, koff;

  assign key_now = key_a | key_b;
  assign kon     = key_now & ~key_held;
  assign koff    = ~key_now & key_held;
  assign ph_rst  = kon;
  assign stage   = st;

  function automatic logic [5:0] eff_rate(input logic [3:0] r, input logic ks, input logic [3:0] kv);
    logic [6:0] s;
    s = {1'b0, r, 2'b00} + {3'b000, (ks ? kv : {2'b00, kv[3:2]})};
    if (r == 4'd0) return 6'd0;
    return (s > 7'd60) ? 6'd60 : s[5:0];
  endfunction

  function automatic logic [3:0] step_inc(input logic [5:0] rate, input logic [CTR_W-1:0] c);
    logic [7:0]       pat;
    logic [3:0]       sh;
    logic [CTR_W-1:0] gate;
    logic [2:0]       pos;
    logic [1:0]       base;
    if (rate[5:2] == 4'd0) return 4'd0;
    if (rate[5:2] <= 4'd12) begin
      case (rate[1:0])
        2'd0:    pat = 8'hAA;
        2'd1:    pat = 8'hBA;
        2'd2:    pat = 8'hEE;
        default: pat = 8'hFE;
      endcase
      sh   = 4'd13 - rate[5:2];
      gate = (ONE << sh) - ONE;
      pos  = 3'(c >> sh);
      return ((c & gate) == '0) ? {3'b000, pat[pos]} : 4'd0;
    end
    case (rate[1:0])
      2'd0:    pat = 8'h00;
      2'd1:    pat = 8'h88;
      2'd2:    pat = 8'hAA;
      default: pat = 8'hEE;
    endcase
    pos  = c[2:0];
    base = 2'd1 + {1'b0, pat[pos]};
    return {2'b00, base} << (rate[5:2] - 4'd13);
  endfunction

  function automatic logic [6:0] ksl_base(input logic [3:0] f);
    case (f)
      4'd0: return 7'd0;   4'd1: return 7'd32;  4'd2: return 7'd40;  4'd3: return 7'd45;
      4'd4: return 7'd48;  4'd5: return 7'd51;  4'd6: return 7'd53;  4'd7: return 7'd55;
      4'd8: return 7'd56;  4'd9: return 7'd58;  4'd10: return 7'd59; 4'd11: return 7'd60;
      4'd12: return 7'd61; 4'd13: return 7'd62; 4'd14: return 7'd63; default: return 7'd64;
    endcase
  endfunction

  logic [5:0] cur_rate, atk_rate;
  logic [3:0] inc;

  always_comb begin
    case (st)
      ST_ATK:         cur_rate = eff_rate(ar, ksr_en, ksv);
      ST_DEC:         cur_rate = eff_rate(dr, ksr_en, ksv);
      ST_SUS, ST_REL: cur_rate = eff_rate(rr, ksr_en, ksv);
      default:        cur_rate = 6'd0;
    endcase
  end

  assign atk_rate = eff_rate(ar, ksr_en, ksv);
  assign inc      = step_inc(cur_rate, ctr);

  logic [12:0] atk_prod;
  logic [9:0]  atk_dec, add_lvl;
  logic [8:0]  atk_lvl, rel_lvl, sus_thr;

  assign atk_prod = ({4'b0000, lvl} + 13'd1) * {9'd0, inc};
  assign atk_dec  = 10'((atk_prod + 13'd7) >> 3);
  assign atk_lvl  = (atk_dec >= {1'b0, lvl}) ? 9'd0 : 9'({1'b0, lvl} - atk_dec);
  assign add_lvl  = {1'b0, lvl} + {6'd0, inc};
  assign rel_lvl  = (add_lvl > 10'h1FF) ? SILENT : add_lvl[8:0];
  assign sus_thr  = (sl == 4'hF) ? 9'd496 : {1'b0, sl, 4'b0000};

  always_comb begin
    st_n  = st;
    lvl_n = lvl;
    if (kon) begin
      if (atk_rate[5:2] == 4'hF) begin
        st_n  = ST_DEC;
        lvl_n = 9'd0;
      end else begin
        st_n = ST_ATK;
      end
    end else if (koff) begin
      st_n = ST_REL;
    end else begin
      case (st)
        ST_OFF: lvl_n = SILENT;
        ST_ATK: if (lvl == 9'd0) st_n = ST_DEC; else lvl_n = atk_lvl;
        ST_DEC: if (lvl >= sus_thr) st_n = ST_SUS; else lvl_n = add_lvl[8:0];
        ST_SUS, ST_REL:
          if (st == ST_REL || !sus_hold) begin
            if (lvl == SILENT) st_n = ST_OFF;
            else               lvl_n = rel_lvl;
          end
        default: st_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_OFF;
      lvl      <= SILENT;
      key_held <= 1'b0;
    end else begin
      st       <= st_n;
      lvl      <= lvl_n;
      key_held <= key_now;
    end
  end

  logic [9:0] ksl_pos, ksl_neg;
  logic [7:0] ksl_raw, ksl_sc;

  assign ksl_pos = {1'b0, ksl_base(fnum_hi), 2'b00};
  assign ksl_neg = {1'b0, (4'd8 - {1'b0, blk}), 5'b00000};
  assign ksl_raw = (ksl_pos > ksl_neg) ? 8'(ksl_pos - ksl_neg) : 8'd0;

  always_comb begin
    case (ksl_sel)
      2'd0:    ksl_sc = 8'd0;
      2'd1:    ksl_sc = ksl_raw >> 1;
      2'd2:    ksl_sc = ksl_raw >> 2;
      default: ksl_sc = ksl_raw;
    endcase
  end

  assign att = ATT_W'(lvl) + ATT_W'({tl, 2'b00}) + ATT_W'(ksl_sc) + ATT_W'(trem);

endmodule

// File: rtl/env_adsr_chk.sv
module env_adsr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ph_rst,
  input logic       key_held,
  input logic [2:0] stage,
  input logic [8:0] lvl
);

  assert_off_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd0) |-> (lvl == 9'h1FF));

  assert_keyon_enters_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ph_rst |=> (stage == 3'd1 || stage == 3'd2));

  assert_no_release_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    key_held |-> (stage != 3'd4));

  assert_attack_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd1) |=> (lvl <= $past(lvl)));

  assert_decay_rises_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd2) |=> (lvl >= $past(lvl)));

endmodule

bind env_adsr env_adsr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ph_rst   (ph_rst),
  .key_held (key_held),
  .stage    (stage),
  .lvl      (lvl)
);

// File: tb/env_adsr_test.sv
module env_adsr_test;

  logic        clk = 1'b0;
  logic        rst_n, key_a, key_b, sus_hold, ksr_en;
  logic [3:0]  ar, dr, sl, rr, ksv, fnum_hi;
  logic [1:0]  ksl_sel;
  logic [2:0]  blk;
  logic [5:0]  tl;
  logic [4:0]  trem;
  logic [15:0] ctr;
  logic [10:0] att;
  logic [2:0]  stage;
  logic        ph_rst;

  always #10 clk = ~clk;

  env_adsr uut (
    .clk(clk), .rst_n(rst_n), .key_a(key_a), .key_b(key_b),
    .ar(ar), .dr(dr), .sl(sl), .rr(rr), .sus_hold(sus_hold), .ksr_en(ksr_en),
    .ksv(ksv), .ksl_sel(ksl_sel), .fnum_hi(fnum_hi), .blk(blk), .tl(tl),
    .trem(trem), .ctr(ctr), .att(att), .stage(stage), .ph_rst(ph_rst)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_st, m_lvl;
  bit m_held;

  task automatic check(int act, int exp, string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int f_rate(int r, bit ks, int kv);
    int s;
    if (r == 0) return 0;
    s = r * 4 + (ks ? kv : kv / 4);
    return (s > 60) ? 60 : s;
  endfunction

  function automatic int f_inc(int rate, int c);
    int lo[4] = '{8'hAA, 8'hBA, 8'hEE, 8'hFE};
    int hi[4] = '{8'h00, 8'h88, 8'hAA, 8'hEE};
    int g = rate / 4, l = rate % 4, sh;
    if (g == 0) return 0;
    if (g <= 12) begin
      sh = 13 - g;
      if ((c % (1 << sh)) != 0) return 0;
      return (lo[l] >> ((c >> sh) & 7)) & 1;
    end
    return (1 + ((hi[l] >> (c & 7)) & 1)) << (g - 13);
  endfunction

  function automatic int f_ksl();
    int t[16] = '{0, 32, 40, 45, 48, 51, 53, 55, 56, 58, 59, 60, 61, 62, 63, 64};
    int v = t[fnum_hi] * 4 - (8 - int'(blk)) * 32;
    if (v < 0) v = 0;
    case (ksl_sel)
      2'd0: return 0;
      2'd1: return v / 2;
      2'd2: return v / 4;
      default: return v;
    endcase
  endfunction

  function automatic int f_att();
    return m_lvl + int'(tl) * 4 + f_ksl() + int'(trem);
  endfunction

  task automatic model_edge();
    bit kn = key_a | key_b;
    int r, inc, thr, d;
    case (m_st)
      1: r = f_rate(ar, ksr_en, ksv);
      2: r = f_rate(dr, ksr_en, ksv);
      3, 4: r = f_rate(rr, ksr_en, ksv);
      default: r = 0;
    endcase
    inc = f_inc(r, int'(ctr));
    if (kn && !m_held) begin
      if (f_rate(ar, ksr_en, ksv) / 4 == 15) begin m_st = 2; m_lvl = 0; end
      else m_st = 1;
    end else if (!kn && m_held) begin
      m_st = 4;
    end else begin
      case (m_st)
        0: m_lvl = 511;
        1: if (m_lvl == 0) m_st = 2;
           else begin
             d = ((m_lvl + 1) * inc + 7) / 8;
             m_lvl = (d >= m_lvl) ? 0 : m_lvl - d;
           end
        2: begin
             thr = (sl == 4'hF) ? 496 : int'(sl) * 16;
             if (m_lvl >= thr) m_st = 3; else m_lvl += inc;
           end
        default:
          if (m_st == 4 || !sus_hold) begin
            if (m_lvl == 511) m_st = 0;
            else begin m_lvl += inc; if (m_lvl > 511) m_lvl = 511; end
          end
      endcase
    end
    m_held = kn;
  endtask

  task automatic cyc(string req);
    #1;
    check(int'(stage), m_st, req);
    check(int'(att), f_att(), req);
    check(int'(ph_rst), int'((key_a | key_b) && !m_held), "R9");
    model_edge();
    @(posedge clk);
    #2;
    ctr = ctr + 16'd1;
  endtask

  task automatic run_until(int tgt, int maxc, string req);
    for (int k = 0; k < maxc && int'(stage) != tgt; k++) cyc(req);
    check(int'(stage), tgt, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int held;
    rst_n = 0; key_a = 0; key_b = 0; ar = 0; dr = 0; sl = 0; rr = 0;
    sus_hold = 0; ksr_en = 0; ksv = 0; ksl_sel = 0; fnum_hi = 0; blk = 0;
    tl = 0; trem = 0; ctr = 0;
    m_st = 0; m_lvl = 511; m_held = 0;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #2;
    check(int'(stage), 0, "R1");
    check(int'(att), 511, "R1");
    rst_n = 1;
    repeat (4) cyc("R1");

    tl = 6'd10; trem = 5'd7; fnum_hi = 4'd15; blk = 3'd7; ksl_sel = 2'd3; #1;
    check(int'(att), 511 + 40 + 224 + 7, "R12");
    ksl_sel = 2'd1; #1; check(int'(att), 511 + 40 + 112 + 7, "R11");
    ksl_sel = 2'd2; #1; check(int'(att), 511 + 40 + 56 + 7, "R11");
    ksl_sel = 2'd0; #1; check(int'(att), 511 + 40 + 7, "R11");
    ksl_sel = 2'd3; blk = 3'd0; #1; check(int'(att), 511 + 40 + 7, "R11");
    fnum_hi = 4'd4; blk = 3'd5; #1; check(int'(att), 511 + 40 + 96 + 7, "R11");
    cyc("R12");
    tl = 0; trem = 0; ksl_sel = 0;

    ar = 4'd15; dr = 4'd13; sl = 4'd8; rr = 4'd15; sus_hold = 1;
    key_a = 1; #1;
    check(int'(ph_rst), 1, "R9");
    cyc("R9");
    #1;
    check(int'(stage), 2, "R9");
    check(int'(att), 0, "R9");
    run_until(3, 400, "R6");
    #1;
    check(int'(att >= 11'd128 && att <= 11'd129), 1, "R6");
    held = int'(att);
    repeat (40) cyc("R7");
    check(int'(att), held, "R7");
    sus_hold = 0;
    run_until(0, 400, "R7");
    #1;
    check(int'(att), 511, "R8");
    repeat (20) cyc("R8");
    check(int'(att), 511, "R8");

    key_a = 0; cyc("R10");
    run_until(0, 50, "R8");
    ar = 4'd10;
    key_a = 1; cyc("R9");
    check(int'(stage), 1, "R9");
    key_b = 1; #1; check(int'(ph_rst), 0, "R10");
    cyc("R10");
    key_a = 0; cyc("R10");
    check(int'(stage), 1, "R10");
    key_b = 0; cyc("R10");
    check(int'(stage), 4, "R10");
    run_until(0, 400, "R8");

    ar = 4'd14; ksr_en = 1; ksv = 4'd4;
    key_a = 1; cyc("R2");
    check(int'(stage), 2, "R2");
    check(int'(att), 0, "R2");
    key_a = 0; cyc("R2");
    run_until(0, 400, "R2");
    ksv = 4'd3;
    key_a = 1; cyc("R2");
    check(int'(stage), 1, "R2");
    key_a = 0; cyc("R2");
    run_until(0, 400, "R2");
    ar = 4'd0; ksv = 4'd15;
    key_a = 1;
    repeat (100) cyc("R2");
    check(int'(stage), 1, "R2");
    check(int'(att), 511, "R2");
    key_a = 0; cyc("R2");
    run_until(0, 400, "R2");

    ar = 4'd12; ksr_en = 0; ksv = 0; dr = 4'd6; sl = 4'd15;
    key_a = 1;
    run_until(2, 4000, "R5");
    repeat (200) cyc("R3");
    key_a = 0;
    run_until(0, 4000, "R8");

    for (int i = 0; i < 30000; i++) begin
      if ($urandom_range(0, 63) == 0) key_a = ~key_a;
      if ($urandom_range(0, 99) == 0) key_b = ~key_b;
      if ($urandom_range(0, 299) == 0) begin
        ar = 4'($urandom_range(4, 15));
        dr = 4'($urandom_range(0, 15));
        rr = 4'($urandom_range(0, 15));
        sl = 4'($urandom_range(0, 15));
        sus_hold = 1'($urandom_range(0, 1));
        ksr_en = 1'($urandom_range(0, 1));
        ksv = 4'($urandom_range(0, 15));
        ksl_sel = 2'($urandom_range(0, 3));
        fnum_hi = 4'($urandom_range(0, 15));
        blk = 3'($urandom_range(0, 7));
        tl = 6'($urandom_range(0, 63));
        trem = 5'($urandom_range(0, 26));
      end
      cyc((i % 2 == 0) ? "R4" : "R3");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule